// File: doc/BRIEF.md
# I2C Target Address Matcher

This block decides whether the first byte after an I2C start condition is addressed to this target and, if so, acknowledges it. It runs on a fast system clock and never looks at SCL directly. A neighbouring front end gives it three one-cycle pulses: one in the cycle where SCL rises, one some cycles after SCL falls, and one when a start condition is seen. The block samples SDA on each rising pulse, checks the first seven bits against a configurable address (most significant bit first), and takes the eighth bit as the read/write direction.

When every address bit matches, the block enables an SDA pull-down for the ninth bit slot, so the controller sees an acknowledge. It releases the pull-down when that slot ends and then raises a success flag. The first bit that differs raises a fail flag at once, and the rest of the byte is ignored. Both outcomes hold until the next start pulse, which clears them and begins a new address phase.

Top module: `i2c_addr_match`

## Requirements
- R1: The seven bits sampled after a start pulse are compared with `tgt_addr_i`, the first sampled bit against `tgt_addr_i[6]` and the seventh against `tgt_addr_i[0]`.
- R2: The eighth sampled bit appears on `rw_o` one clock after its rising strobe (1 = read, 0 = write). A start pulse resets `rw_o` to 0.
- R3: SDA is sampled only in a cycle where `scl_rise_i` is high. SDA changes in other cycles have no effect on any output.
- R4: On a full match, `sda_pull_o` is high from the delayed-falling strobe that ends the eighth bit until the delayed-falling strobe that ends the ninth bit. This makes SDA read low at the ninth rising strobe.
- R5: `sda_pull_o` changes only in the clock after a `scl_fall_dly_i` pulse, or after a start pulse or reset. A delayed-falling strobe seen before the eighth bit has been sampled has no effect.
- R6: When a sampled address bit differs from the expected bit, `match_fail_o` goes high one clock after that rising strobe. `match_ok_o` stays low and `sda_pull_o` stays low for the rest of the byte.
- R7: `match_ok_o` goes high in the same clock as `sda_pull_o` is released at the end of the acknowledge slot. `match_fail_o` stays low in that case, and the two flags are never high together.
- R8: While `rst_ni` is low and after it is released, `match_ok_o`, `match_fail_o`, `sda_pull_o` and `rw_o` are 0 until a start pulse and strobes arrive.
- R9: A start pulse clears `match_ok_o`, `match_fail_o`, `sda_pull_o` and `rw_o` and restarts at the first address bit. This holds even after a mismatch, so a later matching address still ends in success. If a start pulse and a strobe arrive in the same cycle, the start pulse wins.
- R10: Once success or fail is set, further strobes change neither flag nor `rw_o` until the next start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tgt_addr_i | input | 7 | Address this target answers to |
| start_i | input | 1 | One-cycle pulse on a start condition |
| scl_rise_i | input | 1 | One-cycle pulse on SCL rising edge |
| scl_fall_dly_i | input | 1 | One-cycle pulse some cycles after SCL falls |
| sda_i | input | 1 | Synchronised SDA level |
| sda_pull_o | output | 1 | Enable for the SDA pull-down driver |
| rw_o | output | 1 | Captured direction bit, 1 = read |
| match_ok_o | output | 1 | Address matched and acknowledged |
| match_fail_o | output | 1 | Address mismatch detected |

## Verification
The bench aims at the bit order and at the exact clock in which fail rises. A design that compared least significant bit first, or that reported only after the full byte, would show fail late or on the wrong transfer. It toggles SDA between rising strobes to catch a design that samples outside the strobe, and it checks the acknowledge both at the ninth rising strobe and in the cycles around each falling strobe, which exposes pull-down timing tied to the wrong edge. It also sends a mismatch followed by a match, a start pulse landing on a strobe, and extra strobes after the outcome. These catch designs that fail to re-arm, that let a strobe win over start, or that let late strobes disturb held results.

// File: rtl/iam_pkg.sv
package iam_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK_WAIT,
        ST_ACK,
        ST_DONE,
        ST_FAILED
    } iam_state_e;

endpackage

// File: rtl/iam_bit_compare.sv
module iam_bit_compare #(
    parameter int ADDR_W = 7,
    parameter int CNT_W  = $clog2(ADDR_W + 1)
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [CNT_W-1:0]  idx_i,
    input  logic              sda_i,
    output logic              bit_ok_o
);
    localparam int SLOTS = 2 ** CNT_W;

    // Expected bits in arrival order: slot 0 holds the address MSB.
    logic [SLOTS-1:0] expect_seq;

    for (genvar g = 0; g < SLOTS; g++) begin : g_seq
        if (g < ADDR_W) begin : g_addr
            assign expect_seq[g] = addr_i[ADDR_W-1-g];
        end else begin : g_pad
            assign expect_seq[g] = 1'b0;
        end
    end

    always_comb begin
        if (int'(idx_i) < ADDR_W) begin
            bit_ok_o = (sda_i == expect_seq[idx_i]);
        end else begin
            bit_ok_o = 1'b1;
        end
    end

endmodule

// File: rtl/iam_ctrl.sv
module iam_ctrl
    import iam_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int CNT_W  = $clog2(ADDR_W + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic             rise_i,
    input  logic             fall_i,
    input  logic             sda_i,
    input  logic             bit_ok_i,
    output logic [CNT_W-1:0] bit_idx_o,
    output logic             pull_o,
    output logic             rw_o,
    output logic             ok_o,
    output logic             fail_o
);
    localparam logic [CNT_W-1:0] RW_IDX = CNT_W'(ADDR_W);

    typedef struct packed {
        iam_state_e       st;
        logic [CNT_W-1:0] idx;
        logic             pull;
        logic             rw;
        logic             ok;
        logic             fail;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (start_i) begin
            r_d.st   = ST_ADDR;
            r_d.idx  = '0;
            r_d.pull = 1'b0;
            r_d.rw   = 1'b0;
            r_d.ok   = 1'b0;
            r_d.fail = 1'b0;
        end else begin
            unique case (r_q.st)
                ST_ADDR: begin
                    if (rise_i) begin
                        if (r_q.idx == RW_IDX) begin
                            r_d.rw = sda_i;
                            r_d.st = ST_ACK_WAIT;
                        end else if (!bit_ok_i) begin
                            r_d.fail = 1'b1;
                            r_d.st   = ST_FAILED;
                        end else begin
                            r_d.idx = r_q.idx + 1'b1;
                        end
                    end
                end
                ST_ACK_WAIT: begin
                    if (fall_i) begin
                        r_d.pull = 1'b1;
                        r_d.st   = ST_ACK;
                    end
                end
                ST_ACK: begin
                    if (fall_i) begin
                        r_d.pull = 1'b0;
                        r_d.ok   = 1'b1;
                        r_d.st   = ST_DONE;
                    end
                end
                default: begin
                    r_d = r_q;
                end
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q <= '{st: ST_IDLE, idx: '0, pull: 1'b0, rw: 1'b0, ok: 1'b0, fail: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign bit_idx_o = r_q.idx;
    assign pull_o    = r_q.pull;
    assign rw_o      = r_q.rw;
    assign ok_o      = r_q.ok;
    assign fail_o    = r_q.fail;

endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match #(
    parameter int ADDR_W = 7
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] tgt_addr_i,
    input  logic              start_i,
    input  logic              scl_rise_i,
    input  logic              scl_fall_dly_i,
    input  logic              sda_i,
    output logic              sda_pull_o,
    output logic              rw_o,
    output logic              match_ok_o,
    output logic              match_fail_o
);
    localparam int CNT_W = $clog2(ADDR_W + 1);

    logic [CNT_W-1:0] bit_idx;
    logic             bit_ok;

    iam_bit_compare #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W)
    ) u_cmp (
        .addr_i   (tgt_addr_i),
        .idx_i    (bit_idx),
        .sda_i    (sda_i),
        .bit_ok_o (bit_ok)
    );

    iam_ctrl #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W)
    ) u_ctrl (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .start_i   (start_i),
        .rise_i    (scl_rise_i),
        .fall_i    (scl_fall_dly_i),
        .sda_i     (sda_i),
        .bit_ok_i  (bit_ok),
        .bit_idx_o (bit_idx),
        .pull_o    (sda_pull_o),
        .rw_o      (rw_o),
        .ok_o      (match_ok_o),
        .fail_o    (match_fail_o)
    );

endmodule

// File: rtl/iam_checker.sv
module iam_checker (
    input logic clk_i,
    input logic rst_ni,
    input logic start_i,
    input logic scl_fall_dly_i,
    input logic sda_pull_o,
    input logic rw_o,
    input logic match_ok_o,
    input logic match_fail_o
);

    p_flags_exclusive_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(match_ok_o && match_fail_o));

    p_pull_on_fall_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(sda_pull_o) |-> $past(scl_fall_dly_i));

    p_pull_off_timed_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(sda_pull_o) |-> ($past(scl_fall_dly_i) || $past(start_i)));

    p_no_pull_on_fail_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        match_fail_o |-> !sda_pull_o);

    p_ok_at_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(match_ok_o) |-> ($past(sda_pull_o) && !sda_pull_o));

    p_start_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i |=> (!match_ok_o && !match_fail_o && !sda_pull_o && !rw_o));

    p_ok_held_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (match_ok_o && !start_i) |=> (match_ok_o && $stable(rw_o)));

    p_fail_held_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (match_fail_o && !start_i) |=> match_fail_o);

endmodule

bind i2c_addr_match iam_checker u_iam_checker (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .start_i        (start_i),
    .scl_fall_dly_i (scl_fall_dly_i),
    .sda_pull_o     (sda_pull_o),
    .rw_o           (rw_o),
    .match_ok_o     (match_ok_o),
    .match_fail_o   (match_fail_o)
);

// File: tb/tb_i2c_addr_match.sv
`timescale 1ns/1ps
module tb_i2c_addr_match;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] tgt = 7'h00;
    logic       start = 1'b0;
    logic       rise = 1'b0;
    logic       fall = 1'b0;
    logic       drv = 1'b1;
    logic       sda_line;
    logic       pull, rw, ok, fail;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    // Wired-AND bus: the target pull-down wins over the controller.
    assign sda_line = pull ? 1'b0 : drv;

    i2c_addr_match dut (
        .clk_i          (clk),
        .rst_ni         (rst_n),
        .tgt_addr_i     (tgt),
        .start_i        (start),
        .scl_rise_i     (rise),
        .scl_fall_dly_i (fall),
        .sda_i          (sda_line),
        .sda_pull_o     (pull),
        .rw_o           (rw),
        .match_ok_o     (ok),
        .match_fail_o   (fail)
    );

    // Behavioural reference model
    bit   m_active = 0;
    int   m_bits = 0;
    int   m_falls = 0;
    logic m_ok = 0, m_fail = 0, m_pull = 0, m_rw = 0;
    bit   m_got[$];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_active = 0; m_bits = 0; m_falls = 0;
            m_ok = 0; m_fail = 0; m_pull = 0; m_rw = 0;
            m_got.delete();
        end else if (start) begin
            m_active = 1; m_bits = 0; m_falls = 0;
            m_ok = 0; m_fail = 0; m_pull = 0; m_rw = 0;
            m_got.delete();
        end else if (m_active) begin
            if (fall && m_bits == 8) begin
                m_falls++;
                if (m_falls == 1) m_pull = 1;
                if (m_falls == 2) begin m_pull = 0; m_ok = 1; m_active = 0; end
            end else if (rise && m_bits < 8) begin
                m_got.push_back(sda_line);
                if (m_bits == 7) begin
                    m_rw = sda_line;
                    m_bits = 8;
                end else if (sda_line !== tgt[6 - m_bits]) begin
                    m_fail = 1;
                    m_active = 0;
                end else begin
                    m_bits++;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            n_checks++;
            if ({ok, fail, pull, rw} !== {m_ok, m_fail, m_pull, m_rw}) begin
                n_fail++;
                $display("FAIL R1/R2/R4/R6/R7 per-cycle model: got ok=%b fail=%b pull=%b rw=%b exp ok=%b fail=%b pull=%b rw=%b at %0t",
                         ok, fail, pull, rw, m_ok, m_fail, m_pull, m_rw, $time);
            end
        end
    end

    task automatic chk(input bit cond, input string req, input int got, input int exp);
        n_checks++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    logic line_at_rise, fail_after_rise, pull_after_rise, pull_after_fall;

    task automatic slot(input logic b, input bit glitch);
        drv = glitch ? ~b : b;
        tick(1);
        drv = b;
        tick(1);
        rise = 1'b1;
        line_at_rise = sda_line;
        tick(1);
        rise = 1'b0;
        fail_after_rise = fail;
        pull_after_rise = pull;
        if (glitch) drv = ~b;
        tick(1);
        fall = 1'b1;
        tick(1);
        fall = 1'b0;
        pull_after_fall = pull;
        tick(1);
    endtask

    task automatic pulse_start();
        start = 1'b1;
        tick(1);
        start = 1'b0;
        tick(1);
    endtask

    // Sends start, eight bits and a released ack slot; returns the ack level
    task automatic frame(input logic [7:0] v, input bit glitch, output logic ack);
        pulse_start();
        for (int i = 7; i >= 0; i--) slot(v[i], glitch);
        slot(1'b1, 1'b0);
        ack = line_at_rise;
    endtask

    initial begin
        logic ack;
        tick(3);
        chk(!ok && !fail && !pull && !rw, "R8 during reset", {ok, fail, pull, rw}, 0);
        rst_n = 1'b1;
        tick(2);
        chk(!ok && !fail && !pull && !rw, "R8 after reset", {ok, fail, pull, rw}, 0);

        // Write to matching address 0x63
        tgt = 7'h63;
        frame({7'h63, 1'b0}, 0, ack);
        chk(ack == 1'b0, "R4 ack low at ninth rise", ack, 0);
        chk(ok && !fail, "R7 success on match", {ok, fail}, 2);
        chk(rw == 1'b0, "R2 write direction", rw, 0);

        // Read direction, check pull timing around the eighth bit
        pulse_start();
        chk(!ok && !fail, "R9 start clears success", {ok, fail}, 0);
        for (int i = 7; i >= 1; i--) slot(tgt[i-1], 0);
        slot(1'b1, 0);
        chk(pull_after_rise == 1'b0, "R5 no pull at eighth rise", pull_after_rise, 0);
        chk(pull_after_fall == 1'b1, "R4 pull after eighth fall", pull_after_fall, 1);
        chk(rw == 1'b1, "R2 read direction", rw, 1);
        slot(1'b1, 0);
        chk(pull_after_rise == 1'b1, "R4 pull held through ninth rise", pull_after_rise, 1);
        chk(pull_after_fall == 1'b0 && ok, "R7 release then success", {pull_after_fall, ok}, 1);

        // Mismatch on third bit (MSB first order, R1)
        tgt = 7'b1110011;
        pulse_start();
        slot(1'b1, 0);
        slot(1'b1, 0);
        chk(!fail_after_rise, "R1 matching bits no fail", fail_after_rise, 0);
        slot(1'b0, 0);
        chk(fail_after_rise, "R6 fail right after bad bit", fail_after_rise, 1);
        for (int i = 0; i < 5; i++) slot(1'b1, 0);
        slot(1'b1, 0);
        chk(line_at_rise == 1'b1 && !pull, "R6 no ack after mismatch", line_at_rise, 1);
        chk(fail && !ok, "R10 fail held", {ok, fail}, 1);

        // Mismatch then match after re-arm
        tgt = 7'h63;
        frame({7'h63, 1'b1}, 0, ack);
        chk(ok && !fail && ack == 0, "R9 match after mismatch", {ok, fail}, 2);

        // SDA glitches between strobes
        tgt = 7'h2A;
        frame({7'h2A, 1'b0}, 1, ack);
        chk(ok && !fail, "R3 glitches ignored", {ok, fail}, 2);

        // Late strobes after success
        slot(1'b0, 0);
        slot(1'b1, 0);
        chk(ok && !fail && rw == 0 && !pull, "R10 outputs held after success", {ok, fail, rw}, 4);

        // Start colliding with a rising strobe: strobe ignored
        tgt = 7'h40;
        start = 1'b1; rise = 1'b1; drv = 1'b0;
        tick(1);
        start = 1'b0; rise = 1'b0;
        tick(1);
        chk(!fail, "R9 start wins over strobe", fail, 0);
        for (int i = 6; i >= 0; i--) slot(tgt[i], 0);
        slot(1'b0, 0);
        slot(1'b1, 0);
        chk(ok && !fail, "R9 full address after collision", {ok, fail}, 2);

        // Random addresses, half matching
        for (int t = 0; t < 24; t++) begin
            logic [6:0] a;
            logic [7:0] v;
            a = 7'($urandom);
            tgt = a;
            v = {((t % 2) == 0) ? a : 7'($urandom), 1'($urandom)};
            frame(v, t[0], ack);
            chk((ok == (v[7:1] == a)) && (fail == (v[7:1] != a)), "R1 random compare", {ok, fail},
                (v[7:1] == a) ? 2 : 1);
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #400000;
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule